// File: doc/BRIEF.md
# Closed Caption Line Encoder

This block turns a pair of caption bytes into a digital amplitude waveform on one chosen video line in each field. Software-side logic loads a 16-bit pair for field 0 or field 1 into a per-field holding register. On the encoding line of that field, the block emits three things in order: a clock run-in burst, a three-bit start pattern, and the sixteen data bits. The result is a code that the luminance path adds in ahead of the converter.

Every bit lasts one thirty-second of a line period. A fractional accumulator on the system clock produces this timing, given the line length in clocks. The same logic therefore serves 60 Hz and 50 Hz line timing and clock rates that do not divide a line evenly.

The block holds a frame in its per-field register until that field's encoding line comes round. A frame is transmitted once only. If a field reaches its encoding line without fresh data, the block sends a null pair in its place.

Top module: `cc_line_encoder`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `cc_level` is the zero code (0) and `cc_gate` is low.
- R2: The waveform appears only on the target line of a field. The line that carries `field_start` together with `line_start` is line 1, and each later `line_start` adds one. On every other line, `cc_gate` stays low and `cc_level` stays 0.
- R3: The target line is 21 plus `line_adj`, which is read as a signed two's-complement value. For example, 4'hE moves encoding to line 19.
- R4: The active window starts at half-bit slot 6 after the line start and is 52 slots long. The first 14 slots are 7 run-in cycles, each high for its first half-bit and low for its second.
- R5: The three bit periods that follow the run-in carry the start pattern 0, 0, 1 in that order.
- R6: The sixteen data bits follow the start pattern. `wr_data[7:0]` is sent first and `wr_data[15:8]` second, each least significant bit first.
- R7: Each field has its own holding register, chosen by `wr_field` on a write. The frame sent on a line comes from the field given by `field_sel` at the most recent field start.
- R8: A field sends its loaded pair once. On any later encoding line with no new write, it sends the null pair 16'h8080.
- R9: Half-bit slot h covers the clocks after the line start for which floor(64·n / `line_clks`) equals h. This gives exactly 32 bit periods per line for any `line_clks` of 64 or more.
- R10: A one bit is output as code 200 (about 50 IRE) and a zero bit as code 0 (0 IRE). Outside the window the output is 0 and `cc_gate` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle pulse at each horizontal sync |
| field_start | input | 1 | Pulse together with `line_start` on line 1 of a field |
| field_sel | input | 1 | Field identity, sampled at `field_start` |
| line_clks | input | 12 | Line period in system clocks (at least 64) |
| line_adj | input | 4 | Signed shift of the encoding line from 21 |
| wr_en | input | 1 | Load strobe for a byte pair |
| wr_field | input | 1 | Field whose holding register is loaded |
| wr_data | input | 16 | Byte pair: first byte in bits 7:0 |
| cc_level | output | 10 | Amplitude code to add to luminance |
| cc_gate | output | 1 | High while the caption window is being driven |

## Verification
Each fault has its own signature at the ports. A wrong line counter or field register makes the waveform appear on the wrong line, or makes the wrong pair appear, and this is visible within one line. A fault in the fractional accumulator shifts slot boundaries. With a non-dividing line length, the later bits drift by whole clocks before the line ends. A pending flag that fails to clear repeats stale data where the null pair belongs, and this shows on the next encoding line of that field. The bench compares every output cycle of every line against a slot model computed from `line_clks`. It therefore reports a one-clock misplacement of any edge.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int HALVES      = 64;             // half-bit slots per line
  localparam int HALF_W      = $clog2(HALVES);
  localparam int RUNIN_CYC   = 7;
  localparam int FRAME_LEN   = 3;
  localparam logic [FRAME_LEN-1:0] FRAME_CODE = 3'b100; // index 0 is sent first
  localparam int FR_W        = $clog2(FRAME_LEN);
  localparam int DATA_LEN    = 16;
  localparam int DATA_IW     = $clog2(DATA_LEN);
  localparam int WIN_HALVES  = 2 * (RUNIN_CYC + FRAME_LEN + DATA_LEN);
  localparam int NUM_FIELDS  = 2;
  localparam int FIELD_W     = $clog2(NUM_FIELDS);
  localparam logic [DATA_LEN-1:0] NULL_PAIR = 16'h8080;

  typedef logic [DATA_LEN-1:0] cc_pair_t;
endpackage

// File: rtl/cc_half_tick.sv
// Fractional half-bit slot counter: HALVES slots per line_clks clocks.
module cc_half_tick
  import cc_pkg::*;
#(
  parameter int CLK_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_start,
  input  logic [CLK_W-1:0]  line_clks,
  output logic [HALF_W-1:0] half_idx
);
  logic [CLK_W-1:0] acc;
  logic [CLK_W:0]   sum;

  assign sum = {1'b0, acc} + (CLK_W+1)'(HALVES);

  always_ff @(posedge clk) begin
    if (rst || line_start) begin
      acc      <= '0;
      half_idx <= '0;
    end else if (sum >= {1'b0, line_clks}) begin
      acc <= CLK_W'(sum - {1'b0, line_clks});
      if (half_idx != HALF_W'(HALVES-1))
        half_idx <= half_idx + 1'b1;
    end else begin
      acc <= CLK_W'(sum);
    end
  end
endmodule

// File: rtl/cc_field_buf.sv
// Per-field holding registers with pending flags; null pair when not pending.
module cc_field_buf
  import cc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [FIELD_W-1:0] wr_field,
  input  cc_pair_t           wr_data,
  input  logic               take,
  input  logic [FIELD_W-1:0] take_field,
  output cc_pair_t           pair_out
);
  cc_pair_t             hold [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] pend;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    always_ff @(posedge clk) begin
      if (rst) begin
        hold[f] <= NULL_PAIR;
        pend[f] <= 1'b0;
      end else if (wr_en && wr_field == FIELD_W'(f)) begin
        hold[f] <= wr_data;
        pend[f] <= 1'b1;
      end else if (take && take_field == FIELD_W'(f)) begin
        pend[f] <= 1'b0;
      end
    end
  end

  assign pair_out = pend[take_field] ? hold[take_field] : NULL_PAIR;
endmodule

// File: rtl/cc_line_ctrl.sv
// Line and field tracking; flags the start of the encoding line.
module cc_line_ctrl
  import cc_pkg::*;
#(
  parameter int LINE_W       = 10,
  parameter int ADJ_W        = 4,
  parameter int DEFAULT_LINE = 21
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               line_start,
  input  logic               field_start,
  input  logic [FIELD_W-1:0] field_sel,
  input  logic [ADJ_W-1:0]   line_adj,
  output logic               take,
  output logic [FIELD_W-1:0] take_field
);
  logic [LINE_W-1:0]  line_num;
  logic [FIELD_W-1:0] cur_field;
  logic [LINE_W-1:0]  next_line;
  logic [LINE_W-1:0]  target;

  assign target     = LINE_W'(DEFAULT_LINE)
                    + {{(LINE_W-ADJ_W){line_adj[ADJ_W-1]}}, line_adj};
  assign next_line  = field_start ? LINE_W'(1) : line_num + LINE_W'(1);
  assign take_field = field_start ? field_sel : cur_field;
  assign take       = line_start && (next_line == target);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_num  <= '0;
      cur_field <= '0;
    end else if (line_start) begin
      line_num  <= next_line;
      cur_field <= take_field;
    end
  end
endmodule

// File: rtl/cc_line_encoder.sv
module cc_line_encoder
  import cc_pkg::*;
#(
  parameter int CLK_W        = 12,
  parameter int LINE_W       = 10,
  parameter int ADJ_W        = 4,
  parameter int LVL_W        = 10,
  parameter int DEFAULT_LINE = 21,
  parameter int START_HALF   = 6,
  parameter int LVL_LO       = 0,
  parameter int LVL_HI       = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_start,
  input  logic              field_start,
  input  logic              field_sel,
  input  logic [CLK_W-1:0]  line_clks,
  input  logic [ADJ_W-1:0]  line_adj,
  input  logic              wr_en,
  input  logic              wr_field,
  input  logic [15:0]       wr_data,
  output logic [LVL_W-1:0]  cc_level,
  output logic              cc_gate
);
  localparam int BIT_W   = HALF_W - 1;
  localparam int WIN_END = START_HALF + WIN_HALVES;

  logic [HALF_W-1:0]  half_idx;
  logic               take;
  logic [FIELD_W-1:0] take_field;
  cc_pair_t           pair_sel;
  cc_pair_t           frame_q;
  logic               active_q;

  cc_half_tick #(.CLK_W(CLK_W)) u_tick (
    .clk(clk), .rst(rst), .line_start(line_start),
    .line_clks(line_clks), .half_idx(half_idx)
  );

  cc_line_ctrl #(.LINE_W(LINE_W), .ADJ_W(ADJ_W), .DEFAULT_LINE(DEFAULT_LINE)) u_ctrl (
    .clk(clk), .rst(rst), .line_start(line_start), .field_start(field_start),
    .field_sel(field_sel), .line_adj(line_adj),
    .take(take), .take_field(take_field)
  );

  cc_field_buf u_buf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_field(wr_field), .wr_data(wr_data),
    .take(take), .take_field(take_field), .pair_out(pair_sel)
  );

  // Latch the frame for the line that is starting.
  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      frame_q  <= NULL_PAIR;
    end else if (line_start) begin
      active_q <= take;
      if (take) frame_q <= pair_sel;
    end
  end

  // Symbol selection from the half-bit slot.
  logic              in_win;
  logic              sym;
  logic [HALF_W-1:0] k;
  logic [BIT_W-1:0]  bitn;
  logic [FR_W-1:0]   fsel;
  logic [DATA_IW-1:0] dsel;

  assign in_win = active_q
               && (half_idx >= HALF_W'(START_HALF))
               && ({1'b0, half_idx} < (HALF_W+1)'(WIN_END));
  assign k    = half_idx - HALF_W'(START_HALF);
  assign bitn = k[HALF_W-1:1];
  assign fsel = FR_W'(bitn - BIT_W'(RUNIN_CYC));
  assign dsel = DATA_IW'(bitn - BIT_W'(RUNIN_CYC + FRAME_LEN));

  always_comb begin
    if (bitn < BIT_W'(RUNIN_CYC))
      sym = ~k[0];
    else if (bitn < BIT_W'(RUNIN_CYC + FRAME_LEN))
      sym = FRAME_CODE[fsel];
    else
      sym = frame_q[dsel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cc_level <= LVL_W'(LVL_LO);
      cc_gate  <= 1'b0;
    end else begin
      cc_level <= (in_win && sym) ? LVL_W'(LVL_HI) : LVL_W'(LVL_LO);
      cc_gate  <= in_win;
    end
  end
endmodule

// File: rtl/cc_line_encoder_chk.sv
module cc_line_encoder_chk
  import cc_pkg::*;
#(
  parameter int LVL_W      = 10,
  parameter int START_HALF = 6,
  parameter int LVL_LO     = 0,
  parameter int LVL_HI     = 200
) (
  input logic              clk,
  input logic              rst,
  input logic              line_start,
  input logic [HALF_W-1:0] half_idx,
  input logic [LVL_W-1:0]  cc_level,
  input logic              cc_gate
);
  // R1: output idle on the cycle reset is released
  p_idle_after_reset_r1: assert property (@(posedge clk)
    $fell(rst) |-> (cc_level == LVL_W'(LVL_LO) && !cc_gate));

  // R10: only the two amplitude codes ever appear
  p_two_codes_r10: assert property (@(posedge clk) disable iff (rst)
    (cc_level == LVL_W'(LVL_LO) || cc_level == LVL_W'(LVL_HI)));

  // R10: blanking level outside the window
  p_blank_outside_r10: assert property (@(posedge clk) disable iff (rst)
    !cc_gate |-> cc_level == LVL_W'(LVL_LO));

  // R4: window opens only at the fixed slot offset
  p_window_start_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(cc_gate) |-> $past(half_idx) == HALF_W'(START_HALF));

  // R9: slot counter moves by at most one slot per clock within a line
  p_slot_step_r9: assert property (@(posedge clk) disable iff (rst)
    !line_start |=> (half_idx == $past(half_idx) || half_idx == $past(half_idx) + 1'b1));
endmodule

bind cc_line_encoder cc_line_encoder_chk #(
  .LVL_W(LVL_W), .START_HALF(START_HALF), .LVL_LO(LVL_LO), .LVL_HI(LVL_HI)
) u_chk (
  .clk(clk), .rst(rst), .line_start(line_start),
  .half_idx(half_idx), .cc_level(cc_level), .cc_gate(cc_gate)
);

// File: tb/cc_line_encoder_tb.sv
module cc_line_encoder_tb;
  localparam int LINES = 23;
  localparam int START = 6;
  localparam int HI    = 200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        line_start = 1'b0;
  logic        field_start = 1'b0;
  logic        field_sel = 1'b0;
  logic [11:0] line_clks = 12'd128;
  logic [3:0]  line_adj = 4'd0;
  logic        wr_en = 1'b0;
  logic        wr_field = 1'b0;
  logic [15:0] wr_data = 16'h0;
  logic [9:0]  cc_level;
  logic        cc_gate;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cc_line_encoder u_dut (
    .clk(clk), .rst(rst), .line_start(line_start), .field_start(field_start),
    .field_sel(field_sel), .line_clks(line_clks), .line_adj(line_adj),
    .wr_en(wr_en), .wr_field(wr_field), .wr_data(wr_data),
    .cc_level(cc_level), .cc_gate(cc_gate)
  );

  // Expected output m clocks after the line start edge (R4, R5, R6, R9, R10).
  function automatic void expect_at(input int m, input int len, input bit act,
                                    input logic [15:0] fr,
                                    output int lv, output bit g);
    int h, k, b;
    bit v;
    h = (64 * (m - 1)) / len;
    if (h > 63) h = 63;
    k = h - START;
    if (!act || k < 0 || k >= 52) begin
      lv = 0; g = 1'b0;
    end else begin
      g = 1'b1;
      b = k / 2;
      if (b < 7)       v = (k % 2 == 0);   // run-in
      else if (b < 10) v = (b == 9);       // start pattern 0,0,1
      else             v = fr[b - 10];     // data, LSB first
      lv = v ? HI : 0;
    end
  endfunction

  task automatic write_pair(input bit f, input logic [15:0] d);
    wr_en = 1'b1; wr_field = f; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_line(input bit fs, input bit sel, input int len, input bit act,
                          input logic [15:0] fr, input string tag, input int ln);
    int bad = 0;
    int bm = 0, blv = 0, elv = 0;
    bit bg = 1'b0, eg = 1'b0;
    int lv;
    bit g;
    line_start = 1'b1; field_start = fs; field_sel = sel;
    @(posedge clk); @(negedge clk);
    line_start = 1'b0; field_start = 1'b0;
    for (int m = 1; m < len; m++) begin
      @(posedge clk); @(negedge clk);
      expect_at(m, len, act, fr, lv, g);
      if (int'(cc_level) != lv || cc_gate !== g) begin
        if (bad == 0) begin
          bm = m; blv = int'(cc_level); bg = cc_gate; elv = lv; eg = g;
        end
        bad++;
      end
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s line %0d clock %0d: level=%0d gate=%0b expected level=%0d gate=%0b (%0d mismatches)",
               tag, ln, bm, blv, bg, elv, eg, bad);
    end
  endtask

  task automatic run_field(input bit sel, input int len, input int enc_line,
                           input logic [15:0] fr, input string tag);
    line_clks = 12'(len);
    for (int n = 1; n <= LINES; n++)
      run_line(n == 1, sel, len, n == enc_line, fr, tag, n);
  endtask

  // R1
  task automatic t_reset;
    checks++;
    if (cc_level !== 10'd0 || cc_gate !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: level=%0d gate=%0b expected level=0 gate=0", cc_level, cc_gate);
    end
  endtask

  // R2, R4, R5, R6, R10: field 0 pair on line 21, all other lines blank
  task automatic t_basic;
    write_pair(1'b0, 16'h3CA5);
    run_field(1'b0, 128, 21, 16'h3CA5, "R2_R4_R5_R6_R10 basic");
  endtask

  // R7: separate registers per field
  task automatic t_fields;
    write_pair(1'b1, 16'h1234);
    write_pair(1'b0, 16'hFFFF);
    run_field(1'b1, 128, 21, 16'h1234, "R7 field1");
    run_field(1'b0, 128, 21, 16'hFFFF, "R7 field0");
  endtask

  // R8: no new write gives the null pair
  task automatic t_null;
    run_field(1'b0, 128, 21, 16'h8080, "R8 null pair");
  endtask

  // R3: signed line shift moves encoding to line 19
  task automatic t_adjust;
    line_adj = 4'hE;
    write_pair(1'b0, 16'h00F1);
    run_field(1'b0, 128, 19, 16'h00F1, "R3 line shift");
    line_adj = 4'h0;
  endtask

  // R9: non-dividing, longer line (50 Hz style timing)
  task automatic t_long_line;
    write_pair(1'b1, 16'hC3E7);
    run_field(1'b1, 141, 21, 16'hC3E7, "R9 long line");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    t_reset();
    t_basic();
    t_fields();
    t_null();
    t_adjust();
    t_long_line();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule